// File: doc/BRIEF.md
# Recency-Matrix Victim Selector

This block keeps the least-recently-used order of a small set of cache slots. It stores an N-by-N bit matrix with one row and one column for each slot. When slot i is used, row i is filled with ones and column i is then cleared. The slot whose row holds the fewest ones is the oldest. A cache controller gives the slot it touched each cycle through an enable and an index. It reads back a victim index that tells it where the next incoming block goes.

A companion occupancy mask records which slots have been touched since reset. Until every slot has been used once, the victim is the lowest-numbered slot that has never been touched, so empty slots fill before anything is evicted. After that, the victim comes from the matrix. Both the matrix and the mask are registers. The victim index is formed combinationally from them.

Top module: `lru_matrix_tracker`

## Requirements
- R1: Reset is synchronous and active high. It clears the matrix and the occupancy mask, so after reset `victim_slot` is 0 and `slots_full` is 0.
- R2: An enabled access to slot i changes the matrix in that clock edge. Row i becomes all ones except its own diagonal bit, and column i becomes all zeros. Once every slot has been touched, slot i is not the victim in the cycle after its access.
- R3: `slots_full` rises in the cycle after the first access that leaves no slot untouched since reset, and stays high until reset.
- R4: While `slots_full` is high, `victim_slot` is the slot whose most recent access is the oldest (its matrix row is all zeros).
- R5: While `slots_full` is low, `victim_slot` is the lowest-numbered slot that has not been accessed since reset.
- R6: A cycle with `acc_en` low leaves the matrix and the mask unchanged, so `victim_slot` and `slots_full` keep their values.
- R7: Suppose each new block is placed at the current victim slot and then accessed there. With four slots, the block sequence 0, 2, 3, 1, 5, 4 puts blocks 0, 2, 3, 1 in slots 0, 1, 2, 3. Block 5 then goes to slot 0 and block 4 goes to slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Marks `acc_slot` as used this cycle |
| acc_slot | input | IW = max(1, clog2(N)) | Index of the slot being used, below N |
| victim_slot | output | IW | Slot to fill or replace next |
| slots_full | output | 1 | High once every slot has been used since reset |

## Verification
An access counts at the rising edge where `acc_en` is high. Its effect on `victim_slot` and `slots_full` appears right after that same edge, because the only registers on the path are the matrix and the mask. The bench drives stimulus on the falling edge and compares both outputs on the next falling edge, one edge after the access. The expected values come from a per-slot record of the last access time and a touched flag. They are checked on every cycle of an exhaustive sweep of all five-access sequences over four slots, on a pseudo-random run that mixes in idle cycles, and on the fill-then-evict sequence.

// File: rtl/lru_pkg.sv
package lru_pkg;

    typedef enum logic {
        SRC_FILL = 1'b0,
        SRC_AGE  = 1'b1
    } victim_src_e;

    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lru_age_matrix.sv
module lru_age_matrix #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_en,
    input  logic [IW-1:0]         acc_slot,
    output logic [N-1:0][N-1:0]   rows
);

    logic [N-1:0][N-1:0] mat_q;
    logic [N-1:0][N-1:0] mat_d;

    always_comb begin
        mat_d = mat_q;
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                if (acc_slot == IW'(c))
                    mat_d[r][c] = 1'b0;
                else if (acc_slot == IW'(r))
                    mat_d[r][c] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mat_q <= '0;
        else if (acc_en)
            mat_q <= mat_d;
    end

    assign rows = mat_q;

    // R1: matrix is clear after reset
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (mat_q == '0));

    // R2: the used row carries N-1 ones and a zero diagonal
    p_row_set_r2: assert property (@(posedge clk) disable iff (rst)
        acc_en && (int'(acc_slot) < N) |=>
            ($countones(mat_q[$past(acc_slot)]) == N - 1) &&
            !mat_q[$past(acc_slot)][$past(acc_slot)]);

    // R6: idle cycles hold the matrix
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> $stable(mat_q));

endmodule

// File: rtl/lru_oldest_row.sv
module lru_oldest_row #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0][N-1:0] rows,
    output logic [IW-1:0]       oldest
);

    localparam int CW = lru_pkg::cnt_bits(N);

    logic [CW-1:0] ones_cnt [N];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cnt
            assign ones_cnt[g] = CW'($countones(rows[g]));
        end
    endgenerate

    logic [CW-1:0] best_cnt;

    always_comb begin
        oldest   = '0;
        best_cnt = ones_cnt[0];
        for (int r = 1; r < N; r++) begin
            if (ones_cnt[r] < best_cnt) begin
                best_cnt = ones_cnt[r];
                oldest   = IW'(r);
            end
        end
    end

endmodule

// File: rtl/lru_fill_mask.sv
module lru_fill_mask #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_en,
    input  logic [IW-1:0] acc_slot,
    output logic [IW-1:0] free_slot,
    output logic          all_used
);

    logic [N-1:0] used_q;

    always_ff @(posedge clk) begin
        if (rst)
            used_q <= '0;
        else if (acc_en) begin
            for (int i = 0; i < N; i++)
                if (acc_slot == IW'(i))
                    used_q[i] <= 1'b1;
        end
    end

    always_comb begin
        free_slot = '0;
        for (int i = N - 1; i >= 0; i--)
            if (!used_q[i])
                free_slot = IW'(i);
    end

    assign all_used = &used_q;

    // R3: once all slots are used the mask stays full
    p_full_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        all_used |=> all_used);

    // R6: idle cycles hold the mask
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> $stable(used_q));

endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
    parameter  int N  = 4,
    localparam int IW = lru_pkg::idx_bits(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_en,
    input  logic [IW-1:0] acc_slot,
    output logic [IW-1:0] victim_slot,
    output logic          slots_full
);

    import lru_pkg::*;

    logic [N-1:0][N-1:0] rows;
    logic [IW-1:0]       oldest;
    logic [IW-1:0]       free_slot;
    logic                all_used;
    victim_src_e         src;

    lru_age_matrix #(.N(N), .IW(IW)) u_matrix (
        .clk      (clk),
        .rst      (rst),
        .acc_en   (acc_en),
        .acc_slot (acc_slot),
        .rows     (rows)
    );

    lru_oldest_row #(.N(N), .IW(IW)) u_oldest (
        .rows   (rows),
        .oldest (oldest)
    );

    lru_fill_mask #(.N(N), .IW(IW)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (acc_en),
        .acc_slot  (acc_slot),
        .free_slot (free_slot),
        .all_used  (all_used)
    );

    assign src = all_used ? SRC_AGE : SRC_FILL;

    always_comb begin
        case (src)
            SRC_AGE:  victim_slot = oldest;
            default:  victim_slot = free_slot;
        endcase
    end

    assign slots_full = all_used;

    // R1: outputs start from the cleared state
    p_reset_out_r1: assert property (@(posedge clk) rst |=>
        (victim_slot == '0) && !slots_full);

    // R3: the mask only fills on an enabled access
    p_full_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(slots_full) |-> $past(acc_en));

    // R2: with all slots used, the slot just accessed is not the victim
    p_mru_not_victim_r2: assert property (@(posedge clk) disable iff (rst)
        (N > 1) && acc_en && slots_full |=> (victim_slot != $past(acc_slot)));

    // R4: with all slots used, the victim's row is empty
    p_victim_row_zero_r4: assert property (@(posedge clk) disable iff (rst)
        slots_full |-> (rows[victim_slot] == '0));

    // R6: an idle cycle keeps the victim
    p_victim_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> $stable(victim_slot) && $stable(slots_full));

endmodule

// File: tb/lru_matrix_tracker_test.sv
`timescale 1ns/1ps
module lru_matrix_tracker_test;

    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_en = 1'b0;
    logic [IW-1:0] acc_slot = '0;
    logic [IW-1:0] victim_slot;
    logic          slots_full;

    int checks = 0;
    int errors = 0;
    int last_t [N];
    bit touched [N];
    int now_t = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lru_matrix_tracker #(.N(N)) uut (
        .clk         (clk),
        .rst         (rst),
        .acc_en      (acc_en),
        .acc_slot    (acc_slot),
        .victim_slot (victim_slot),
        .slots_full  (slots_full)
    );

    function automatic int exp_victim();
        for (int i = 0; i < N; i++)
            if (!touched[i]) return i;
        begin
            int best = 0;
            for (int i = 1; i < N; i++)
                if (last_t[i] < last_t[best]) best = i;
            return best;
        end
    endfunction

    function automatic bit exp_full();
        for (int i = 0; i < N; i++)
            if (!touched[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string tag);
        int ev;
        bit ef;
        ev = exp_victim();
        ef = exp_full();
        checks++;
        if (int'(victim_slot) != ev || slots_full != ef) begin
            errors++;
            $display("FAIL %s: victim=%0d full=%0d expected victim=%0d full=%0d",
                     tag, victim_slot, slots_full, ev, ef);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        acc_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) begin
            touched[i] = 1'b0;
            last_t[i] = 0;
        end
        check("R1 reset state");
    endtask

    // called at a falling edge; checks at the next falling edge
    task automatic step(input bit en, input int sl, input string tag);
        acc_en = en;
        acc_slot = sl[IW-1:0];
        @(posedge clk);
        if (en) begin
            now_t++;
            touched[sl] = 1'b1;
            last_t[sl] = now_t;
        end
        @(negedge clk);
        acc_en = 1'b0;
        check(tag);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lcg;
        int exp_slot [6];
        string tg;
        exp_slot = '{0, 1, 2, 3, 0, 1};

        // exhaustive five-access sequences (R2, R3, R4, R5)
        for (int s = 0; s < 1024; s++) begin
            do_reset();
            for (int k = 0; k < 5; k++) begin
                int sl;
                sl = (s >> (2 * k)) & 3;
                tg = exp_full() ? "R2 R4 aged victim" : "R3 R5 fill victim";
                step(1'b1, sl, tg);
            end
        end

        // fill-then-evict placement (R7)
        do_reset();
        for (int b = 0; b < 6; b++) begin
            checks++;
            if (int'(victim_slot) != exp_slot[b]) begin
                errors++;
                $display("FAIL R7: block index %0d placed at %0d expected %0d",
                         b, victim_slot, exp_slot[b]);
            end
            step(1'b1, int'(victim_slot), "R7 placement");
        end

        // mixed idle and access cycles (R6, R4)
        do_reset();
        lcg = 12345;
        for (int k = 0; k < 3000; k++) begin
            bit en;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            en = ((lcg >> 16) % 3) != 0;
            step(en, (lcg >> 8) & 3, en ? "R4 R5 random access" : "R6 idle hold");
            if (k == 1500) do_reset();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule